// File: doc/BRIEF.md
# Constrained Power-of-Two Clock Ratio Controller

This block holds a single 16-bit clock-ratio word. The word carries six 2-bit divider exponents, one for each clock domain: core, DSP, DSP memory-management unit, traffic controller, LCD and peripheral. Each exponent drives its own enable generator. That generator marks one cycle out of every 2^e cycles of the common input clock, so the domain runs at the input rate divided by 1, 2, 4 or 8. Every value stored in the word is first passed through a normaliser. The normaliser rewrites the exponent fields so that the rate relationships between the domains always hold. The fields therefore do not act as independent divider settings.

The word can be loaded in two ways. A direct write stores the normalised form of the data supplied. A rate request names one domain and gives a target rate and a parent rate. The block picks the smallest exponent that brings the parent rate at or below the target. It places that exponent in the named field, normalises the whole word and stores it. The block then reports acceptance or rejection with a one-cycle pulse.

Top module: `clkratio_ctrl`

## Requirements
- R1: Exponent fields sit at bits [2i+1:2i] of the word, for i = 0 core, 1 DSP, 2 DSP-MMU, 3 traffic controller, 4 LCD and 5 peripheral. Domain i's enable output is high in exactly one cycle of every 2^e, where e is the stored exponent. An exponent of 0 gives an enable in every cycle.
- R2: After normalisation the DSP-MMU exponent lies between the DSP exponent and the DSP exponent plus one. It is raised to the lower limit when below it and lowered to the upper limit when above it.
- R3: After normalisation the traffic-controller exponent is at least the core exponent and at least the corrected DSP-MMU exponent.
- R4: After normalisation the LCD and peripheral exponents are each at least the final traffic-controller exponent.
- R5: Bits [15:12] are stored exactly as supplied. The word read back in the cycle after a write is the normalised form of the written data.
- R6: A rate request (parent P, target T, field selector 0..5) chooses the smallest e in 0..3 with floor(P/2^e) <= T. It puts e in that field, normalises and stores the word, and pulses req_ok high for the one cycle after the request.
- R7: If floor(P/8) > T, the request is rejected: req_err pulses for one cycle and the stored word is unchanged.
- R8: A request with P = 0, or with a field selector of 6 or 7, is rejected the same way, and the word is unchanged.
- R9: When a write and a request arrive in the same cycle, the write is stored and the request is rejected with req_err.
- R10: When an exponent changes, the enable period already in progress ends at its old length. Every period after that uses the new length.
- R11: After reset the word is 0, all six enables are high in the first cycle, and req_ok and req_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store the normalised form of wr_data |
| wr_data | input | 16 | Ratio word to write |
| rd_data | output | 16 | Stored ratio word |
| req_valid | input | 1 | Rate request strobe |
| req_sel | input | 3 | Field selected by the request (0..5) |
| req_target | input | RATE_W | Target rate |
| req_parent | input | RATE_W | Parent rate |
| req_ok | output | 1 | One-cycle pulse: request accepted |
| req_err | output | 1 | One-cycle pulse: request rejected |
| clk_en | output | 6 | Per-domain clock enables, same index order as the fields |

## Verification
The bench applies words in which the DSP-MMU exponent lies both below and above its window. A normaliser that clamped only one side would store an MMU/DSP pair that breaks R2. Other words make the traffic-controller floor come from the core exponent in one case and from the corrected MMU exponent in another. This exposes an ordering fault, in which the traffic-controller field would be compared against the raw MMU value. Rate requests are driven exactly at the divide boundaries, where the target equals the halved parent and where it sits one below it. An off-by-one comparison would then pick the wrong exponent or accept a rejected request. The bench also changes an exponent in the cycle where its enable fires. An enable generator that reloaded immediately would pulse early instead of finishing the old period.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;
    localparam int NUM_DOM    = 6;
    localparam int EXP_W      = 2;
    localparam int CTL_W      = 16;
    localparam int FIELD_BITS = NUM_DOM * EXP_W;
    localparam int UPPER_W    = CTL_W - FIELD_BITS;
    localparam int SEL_W      = 3;

    typedef logic [EXP_W-1:0] exp_t;

    // Packed MSB first: upper bits, then peripheral down to core at bit 0.
    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        exp_t               per;
        exp_t               lcd;
        exp_t               tc;
        exp_t               mmu;
        exp_t               dsp;
        exp_t               core;
    } ctl_t;
endpackage

// File: rtl/ratio_normalizer.sv
module ratio_normalizer
    import clkratio_pkg::*;
(
    input  ctl_t raw_i,
    output ctl_t norm_o
);
    localparam int WIDE_W = EXP_W + 1;

    logic [WIDE_W-1:0] mmu_w;
    logic [WIDE_W-1:0] dsp_lo_w;
    logic [WIDE_W-1:0] dsp_hi_w;
    logic [WIDE_W-1:0] tc_w;
    logic [WIDE_W-1:0] lcd_w;
    logic [WIDE_W-1:0] per_w;

    always_comb begin
        dsp_lo_w = {1'b0, raw_i.dsp};
        dsp_hi_w = dsp_lo_w + 1'b1;

        // DSP-MMU window first; the traffic-controller floor depends on it.
        mmu_w = {1'b0, raw_i.mmu};
        if (mmu_w < dsp_lo_w) mmu_w = dsp_lo_w;
        if (mmu_w > dsp_hi_w) mmu_w = dsp_hi_w;

        tc_w = {1'b0, raw_i.tc};
        if (tc_w < {1'b0, raw_i.core}) tc_w = {1'b0, raw_i.core};
        if (tc_w < mmu_w)              tc_w = mmu_w;

        lcd_w = {1'b0, raw_i.lcd};
        if (lcd_w < tc_w) lcd_w = tc_w;
        per_w = {1'b0, raw_i.per};
        if (per_w < tc_w) per_w = tc_w;

        norm_o       = raw_i;
        norm_o.mmu   = mmu_w[EXP_W-1:0];
        norm_o.tc    = tc_w[EXP_W-1:0];
        norm_o.lcd   = lcd_w[EXP_W-1:0];
        norm_o.per   = per_w[EXP_W-1:0];
    end
endmodule

// File: rtl/rate_exp_calc.sv
module rate_exp_calc #(
    parameter int RATE_W = 32,
    parameter int EXP_W  = 2
) (
    input  logic [RATE_W-1:0] parent_i,
    input  logic [RATE_W-1:0] target_i,
    output logic [EXP_W-1:0]  exp_o,
    output logic              found_o
);
    localparam int MAX_EXP = (1 << EXP_W) - 1;

    always_comb begin
        found_o = 1'b0;
        exp_o   = EXP_W'(MAX_EXP);
        // Walk from the slowest choice down so the last hit is the smallest.
        for (int i = MAX_EXP; i >= 0; i--) begin
            if ((parent_i >> i) <= target_i) begin
                found_o = 1'b1;
                exp_o   = EXP_W'(i);
            end
        end
    end
endmodule

// File: rtl/pow2_enable_gen.sv
module pow2_enable_gen #(
    parameter int EXP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_i,
    output logic             en_o
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   span;

    assign en_o = (cnt_q == '0);

    always_comb begin
        span = (CNT_W+1)'(1) << exp_i;
        // Reload only at terminal count; the live exponent sets the next period.
        if (en_o) cnt_d = CNT_W'(span - 1'b1);
        else      cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: divide-by-one keeps the enable high every cycle
    a_r1_div1_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && exp_i == '0) |=> en_o);

    // R10: a non-unity period never yields back-to-back enables
    a_r10_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && exp_i != '0) |=> !en_o);
endmodule

// File: rtl/clkratio_ctrl.sv
module clkratio_ctrl
    import clkratio_pkg::*;
#(
    parameter int RATE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTL_W-1:0]    wr_data,
    output logic [CTL_W-1:0]    rd_data,
    input  logic                req_valid,
    input  logic [SEL_W-1:0]    req_sel,
    input  logic [RATE_W-1:0]   req_target,
    input  logic [RATE_W-1:0]   req_parent,
    output logic                req_ok,
    output logic                req_err,
    output logic [NUM_DOM-1:0]  clk_en
);
    typedef struct packed {
        ctl_t ctl;
        logic ok;
        logic err;
    } state_t;

    state_t st_d, st_q;

    ctl_t              wr_norm;
    ctl_t              req_raw;
    ctl_t              req_norm;
    exp_t              calc_exp;
    logic              calc_found;
    logic [CTL_W-1:0]  merged_vec;
    logic              req_bad;

    ratio_normalizer u_norm_wr (
        .raw_i  (ctl_t'(wr_data)),
        .norm_o (wr_norm)
    );

    rate_exp_calc #(.RATE_W(RATE_W), .EXP_W(EXP_W)) u_calc (
        .parent_i (req_parent),
        .target_i (req_target),
        .exp_o    (calc_exp),
        .found_o  (calc_found)
    );

    always_comb begin
        merged_vec = st_q.ctl;
        for (int i = 0; i < NUM_DOM; i++) begin
            if (req_sel == SEL_W'(i)) merged_vec[i*EXP_W +: EXP_W] = calc_exp;
        end
        req_raw = ctl_t'(merged_vec);
    end

    ratio_normalizer u_norm_req (
        .raw_i  (req_raw),
        .norm_o (req_norm)
    );

    assign req_bad = (req_parent == '0) || (req_sel >= SEL_W'(NUM_DOM)) || !calc_found;

    always_comb begin
        st_d     = st_q;
        st_d.ok  = 1'b0;
        st_d.err = 1'b0;
        if (wr_en) begin
            st_d.ctl = wr_norm;
            st_d.err = req_valid;
        end else if (req_valid) begin
            if (req_bad) begin
                st_d.err = 1'b1;
            end else begin
                st_d.ctl = req_norm;
                st_d.ok  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.ctl;
    assign req_ok  = st_q.ok;
    assign req_err = st_q.err;

    logic [CTL_W-1:0] ctl_vec;
    assign ctl_vec = st_q.ctl;

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        pow2_enable_gen #(.EXP_W(EXP_W)) u_gen (
            .clk   (clk),
            .rst_n (rst_n),
            .exp_i (ctl_vec[g*EXP_W +: EXP_W]),
            .en_o  (clk_en[g])
        );
    end

    // R2: stored DSP-MMU exponent stays inside its window
    a_r2_mmu_window: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.mmu >= st_q.ctl.dsp) &&
        ({1'b0, st_q.ctl.mmu} <= ({1'b0, st_q.ctl.dsp} + 1'b1)));

    // R3: traffic controller never faster than core or DSP-MMU
    a_r3_tc_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.tc >= st_q.ctl.core) && (st_q.ctl.tc >= st_q.ctl.mmu));

    // R4: LCD and peripheral never faster than traffic controller
    a_r4_slow_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.lcd >= st_q.ctl.tc) && (st_q.ctl.per >= st_q.ctl.tc));

    // R5: upper bits of a write arrive unchanged
    a_r5_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[CTL_W-1 -: UPPER_W] == $past(wr_data[CTL_W-1 -: UPPER_W])));

    // R8: a zero parent rate leaves the word alone and flags an error
    a_r8_zero_parent_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wr_en && req_parent == '0) |=> ($stable(rd_data) && req_err));

    // R6: accept and reject never pulse together
    a_r6_resp_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ok && req_err));
endmodule

// File: tb/clkratio_ctrl_test.sv
module clkratio_ctrl_test;
    localparam int RATE_W = 32;
    localparam int NVEC   = 8;

    // {write data, expected stored word}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'hA000, 16'hA000},   // R5 upper only
        {16'h0003, 16'h0FC3},   // R3/R4 core drives floor
        {16'h5008, 16'h5AA8},   // R2 mmu raised to dsp
        {16'h0034, 16'h0AA4},   // R2 mmu lowered to dsp+1
        {16'hF03C, 16'hFFFC},   // R4 all slowest
        {16'h3E51, 16'h3E51},   // legal word unchanged
        {16'h0C01, 16'h0D41},   // R3 tc from core, R4 lcd raised
        {16'h84D8, 16'h8FE8}    // R3 tc vs corrected mmu
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [15:0]        wr_data = '0;
    logic [15:0]        rd_data;
    logic               req_valid = 1'b0;
    logic [2:0]         req_sel = '0;
    logic [RATE_W-1:0]  req_target = '0;
    logic [RATE_W-1:0]  req_parent = '0;
    logic               req_ok;
    logic               req_err;
    logic [5:0]         clk_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    clkratio_ctrl #(.RATE_W(RATE_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .req_valid(req_valid), .req_sel(req_sel),
        .req_target(req_target), .req_parent(req_parent),
        .req_ok(req_ok), .req_err(req_err), .clk_en(clk_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_req(input logic [2:0] sel, input int tgt, input int par);
        req_valid  = 1'b1;
        req_sel    = sel;
        req_target = RATE_W'(tgt);
        req_parent = RATE_W'(par);
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 word", rd_data, 0);
        chk("R11 enables", clk_en, 6'h3F);
        chk("R11 resp", {req_ok, req_err}, 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            do_write(VEC[v][31:16]);
            chk("R2/R3/R4/R5 vector", rd_data, VEC[v][15:0]);
        end

        // R1 enable rates: core0 dsp1 mmu1 tc2 lcd2 per3
        do_write(16'h0E94);
        chk("R1 legal word", rd_data, 16'h0E94);
        repeat (16) @(negedge clk);
        begin
            int cnt [6];
            int e   [6] = '{0, 1, 1, 2, 2, 3};
            for (int i = 0; i < 6; i++) cnt[i] = 0;
            for (int k = 0; k < 64; k++) begin
                for (int i = 0; i < 6; i++) if (clk_en[i]) cnt[i]++;
                @(negedge clk);
            end
            for (int i = 0; i < 6; i++) chk("R1 enable count", cnt[i], 64 >> e[i]);
        end

        // R10 in-flight period completes at old length
        do_write(16'h0C00);
        repeat (10) @(negedge clk);
        while (!clk_en[5]) @(negedge clk);
        do_write(16'h0000);
        for (int k = 1; k <= 9; k++) begin
            chk("R10 old period", clk_en[5], (k >= 8) ? 1 : 0);
            @(negedge clk);
        end

        // R6 requests
        do_req(3'd1, 300, 1000);
        chk("R6 dsp e=2 word", rd_data, 16'h0AA8);
        chk("R6 ok pulse", {req_ok, req_err}, 2'b10);
        @(negedge clk);
        chk("R6 ok one cycle", req_ok, 0);
        do_req(3'd0, 400, 800);
        chk("R6 boundary e=1", rd_data, 16'h0AA9);
        do_req(3'd4, 60, 50);
        chk("R6 e=0 then floored", rd_data, 16'h0AA9);
        chk("R6 ok", {req_ok, req_err}, 2'b10);

        // R7 too fast even at /8, then exact /8 boundary
        do_req(3'd5, 124, 1000);
        chk("R7 reject word", rd_data, 16'h0AA9);
        chk("R7 err", {req_ok, req_err}, 2'b01);
        do_req(3'd5, 125, 1000);
        chk("R7 boundary accept", rd_data, 16'h0EA9);
        chk("R7 boundary ok", {req_ok, req_err}, 2'b10);

        // R8 zero parent and bad selector
        do_req(3'd0, 5, 0);
        chk("R8 zero parent word", rd_data, 16'h0EA9);
        chk("R8 zero parent err", {req_ok, req_err}, 2'b01);
        do_req(3'd6, 8, 8);
        chk("R8 bad sel word", rd_data, 16'h0EA9);
        chk("R8 bad sel err", {req_ok, req_err}, 2'b01);

        // R9 write and request collide
        wr_en = 1'b1; wr_data = 16'h1000;
        do_req(3'd0, 1, 8);
        wr_en = 1'b0;
        chk("R9 write wins", rd_data, 16'h1000);
        chk("R9 request err", {req_ok, req_err}, 2'b01);

        // R11 reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 re-reset word", rd_data, 0);
        chk("R11 re-reset enables", clk_en, 6'h3F);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule